// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block is the receive half of a buffered synchronous serial port. A serial bit stream arrives together with a frame sync line. The bit clock is presented to the block as a one-cycle strobe in the system clock domain. The receiver stays idle until it samples the frame sync high on a bit strobe. It then waits a programmable number of bit strobes (the data delay) and shifts in a fixed number of words, most significant bit first. When the frame is complete it returns to idle.

Each completed word passes from the shift register into a one-word holding buffer, and from there into the host data register. The host data register is presented zero-filled and justified inside a wider host word. A ready flag tells the host that an unread word is present. A one-cycle event pulse per delivered word lets a DMA engine fetch one word per event. An interrupt line has four selectable causes. If a word completes while both the data register and the holding buffer are occupied, the word is discarded and a sticky overrun flag is raised. Driving the receiver enable low holds the whole receive path in reset. Any frame that arrives while the enable is low is lost, so the receiver must be enabled before its frame source starts sending.

Top module: `framed_rx`

## Requirements
- R1: After reset, or while `rx_enable` is low, `rx_ready`, `rx_overrun`, `rx_event` and `rx_irq` are 0. Bits and frame syncs presented while `rx_enable` is low are lost and produce no word.
- R2: The receiver only leaves idle when `rx_fsync` is 1 on a `bit_tick` cycle. Data bits seen without such a sync produce no word. A sync pulse that arrives while a frame is being received is ignored.
- R3: With the default `DELAY` of 1, the first data bit is taken on the first `bit_tick` after the sync tick, and the bit that arrives with the sync tick is discarded. Words are `WORD_W` bits long and sent MSB first, and `FRAME_WORDS` words follow back to back in one frame.
- R4: `rx_ready` and `rx_event` go high in the clock cycle that follows the second rising edge after the edge that sampled a word's last bit. At the first edge the word is written into the holding buffer; at the second it moves into the data register.
- R5: With `JUSTIFY`=0 the word sits in `rd_data[WORD_W-1:0]` and the upper bits are 0. With `JUSTIFY`=1 it sits in the top `WORD_W` bits and the lower bits are 0.
- R6: While no read is made, `rx_ready` stays 1 and `rd_data` stays stable. When `rd_en` is high with `rx_ready` 1, `rx_ready` is 0 after that edge.
- R7: If the holding buffer holds a word when a read is made, that word enters the data register one cycle later. `rx_ready` returns to 1 and a new `rx_event` pulse is issued.
- R8: A word that completes while both the data register and the holding buffer are full is dropped, and the stored words are kept. `rx_overrun` then becomes 1 and stays 1 until `rx_enable` goes low.
- R9: `rx_event` is a one-cycle pulse for every word that enters the data register, and it carries that word on `rd_data`.
- R10: With `irq_mode`=2'b00, `rx_irq` pulses together with every `rx_event`.
- R11: With `irq_mode`=2'b01, `rx_irq` pulses only when the last word of a frame enters the data register, which is once per frame.
- R12: With `irq_mode`=2'b10, `rx_irq` pulses in the cycle after the edge that accepted a frame sync, which is once per frame.
- R13: With `irq_mode`=2'b11, `rx_irq` pulses in the cycle in which each dropped word sets or keeps `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; low holds the receive path in reset |
| bit_tick | input | 1 | One-cycle strobe marking a receive bit clock edge |
| rx_fsync | input | 1 | Active-high frame sync, sampled on `bit_tick` |
| rx_sdata | input | 1 | Serial data, sampled on `bit_tick` |
| irq_mode | input | 2 | Interrupt cause select (see R10 to R13) |
| rd_en | input | 1 | Host read strobe of the data register |
| rd_data | output | HOST_W | Justified, zero-filled received word |
| rx_ready | output | 1 | Unread word present in the data register |
| rx_event | output | 1 | One-cycle per-word read event for a DMA engine |
| rx_irq | output | 1 | Interrupt pulse, cause chosen by `irq_mode` |
| rx_overrun | output | 1 | Sticky flag: a completed word was dropped |

## Verification
Every result has a fixed due cycle. A frame-sync interrupt is due one edge after the sync tick. A delivered word, with its ready flag and event, is due two edges after the tick that carried its last bit. A read clears ready one edge later, and a waiting buffered word returns one edge after that. The bench drives inputs on falling edges and samples on falling edges. It checks the latency cycle by cycle at those exact falling edges, and a scoreboard compares every event against the queue of words the driver sent. Interrupt, overrun and drop behaviour is checked by counting pulses across whole frames, so an extra or missing pulse is caught wherever it falls.

// File: rtl/frx_pkg.sv
package frx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DELAY = 2'd1,
      PH_SHIFT = 2'd2
   } rx_phase_t;

   typedef enum logic [1:0] {
      IRQ_ELEM      = 2'b00,
      IRQ_FRAME_END = 2'b01,
      IRQ_SYNC      = 2'b10,
      IRQ_OVERRUN   = 2'b11
   } irq_cause_t;

   localparam int JUST_RIGHT = 0;
   localparam int JUST_LEFT  = 1;

   function automatic int width_of(input int count);
      return (count <= 1) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/frx_deser.sv
module frx_deser
   import frx_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int FRAME_WORDS = 2,
   parameter int DELAY       = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              bit_tick,
   input  logic              fsync,
   input  logic              sdata,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic              word_last,
   output logic              sync_seen
);

   localparam int BCW = width_of(WORD_W);
   localparam int WCW = width_of(FRAME_WORDS);
   localparam int DCW = width_of(DELAY + 1);
   localparam logic [BCW-1:0] LAST_BIT  = BCW'(WORD_W - 1);
   localparam logic [WCW-1:0] LAST_WORD = WCW'(FRAME_WORDS - 1);
   localparam logic [DCW-1:0] DLY_LOAD  = (DELAY > 0) ? DCW'(DELAY - 1) : '0;

   rx_phase_t         phase;
   logic [BCW-1:0]    bcnt;
   logic [WCW-1:0]    wcnt;
   logic [DCW-1:0]    dcnt;
   logic [WORD_W-1:0] shreg;
   logic              sync_hit;
   logic              data_tick;
   logic [WORD_W-1:0] shifted;

   assign sync_hit  = bit_tick && (phase == PH_IDLE) && fsync;
   assign data_tick = bit_tick && ((phase == PH_SHIFT) ||
                                   ((phase == PH_DELAY) && (dcnt == '0)) ||
                                   ((DELAY == 0) && sync_hit));
   assign shifted   = {shreg[WORD_W-2:0], sdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         bcnt       <= '0;
         wcnt       <= '0;
         dcnt       <= '0;
         shreg      <= '0;
         word_valid <= 1'b0;
         word_data  <= '0;
         word_last  <= 1'b0;
         sync_seen  <= 1'b0;
      end else if (!enable) begin
         phase      <= PH_IDLE;
         bcnt       <= '0;
         wcnt       <= '0;
         dcnt       <= '0;
         shreg      <= '0;
         word_valid <= 1'b0;
         word_last  <= 1'b0;
         sync_seen  <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         sync_seen  <= 1'b0;
         if (sync_hit) begin
            sync_seen <= 1'b1;
            bcnt      <= '0;
            wcnt      <= '0;
            dcnt      <= DLY_LOAD;
            phase     <= PH_DELAY;
         end
         if (data_tick) begin
            shreg <= shifted;
            if (bcnt == LAST_BIT) begin
               word_valid <= 1'b1;
               word_data  <= shifted;
               word_last  <= (wcnt == LAST_WORD);
               bcnt       <= '0;
               if (wcnt == LAST_WORD) begin
                  phase <= PH_IDLE;
                  wcnt  <= '0;
               end else begin
                  phase <= PH_SHIFT;
                  wcnt  <= wcnt + 1'b1;
               end
            end else begin
               bcnt  <= bcnt + 1'b1;
               phase <= PH_SHIFT;
            end
         end else if (bit_tick && (phase == PH_DELAY)) begin
            dcnt <= dcnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/frx_buffer.sv
module frx_buffer #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_last,
   input  logic              rd_en,
   output logic [WORD_W-1:0] out_data,
   output logic              ready,
   output logic              overrun,
   output logic              load_pulse,
   output logic              load_last,
   output logic              ovr_pulse
);

   logic [WORD_W-1:0] hold_q;
   logic              hold_last;
   logic              hold_full;
   logic              move;
   logic              accept;

   assign move   = hold_full && !ready;
   assign accept = in_valid && (!hold_full || move);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= '0;
         hold_last  <= 1'b0;
         hold_full  <= 1'b0;
         out_data   <= '0;
         ready      <= 1'b0;
         overrun    <= 1'b0;
         load_pulse <= 1'b0;
         load_last  <= 1'b0;
         ovr_pulse  <= 1'b0;
      end else if (!enable) begin
         hold_full  <= 1'b0;
         hold_last  <= 1'b0;
         ready      <= 1'b0;
         overrun    <= 1'b0;
         load_pulse <= 1'b0;
         load_last  <= 1'b0;
         ovr_pulse  <= 1'b0;
      end else begin
         load_pulse <= move;
         load_last  <= move && hold_last;
         ovr_pulse  <= in_valid && !accept;
         if (in_valid && !accept)
            overrun <= 1'b1;
         if (move) begin
            out_data <= hold_q;
            ready    <= 1'b1;
         end else if (rd_en && ready) begin
            ready <= 1'b0;
         end
         if (accept) begin
            hold_q    <= in_data;
            hold_last <= in_last;
            hold_full <= 1'b1;
         end else if (move) begin
            hold_full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/frx_justify.sv
module frx_justify
   import frx_pkg::*;
#(
   parameter int WORD_W  = 8,
   parameter int HOST_W  = 32,
   parameter int JUSTIFY = JUST_RIGHT
) (
   input  logic [WORD_W-1:0] word,
   output logic [HOST_W-1:0] host
);

   localparam int PAD_W = HOST_W - WORD_W;

   generate
      if (PAD_W == 0) begin : g_same
         assign host = word;
      end else if (JUSTIFY == JUST_LEFT) begin : g_left
         assign host = {word, {PAD_W{1'b0}}};
      end else begin : g_right
         assign host = {{PAD_W{1'b0}}, word};
      end
   endgenerate

endmodule

// File: rtl/frx_irq.sv
module frx_irq
   import frx_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       load_pulse,
   input  logic       load_last,
   input  logic       sync_pulse,
   input  logic       ovr_pulse,
   output logic       irq
);

   always_comb begin
      case (irq_cause_t'(mode))
         IRQ_ELEM:      irq = load_pulse;
         IRQ_FRAME_END: irq = load_last;
         IRQ_SYNC:      irq = sync_pulse;
         default:       irq = ovr_pulse;
      endcase
   end

endmodule

// File: rtl/framed_rx.sv
module framed_rx
   import frx_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int HOST_W      = 32,
   parameter int FRAME_WORDS = 2,
   parameter int DELAY       = 1,
   parameter int JUSTIFY     = JUST_RIGHT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              bit_tick,
   input  logic              rx_fsync,
   input  logic              rx_sdata,
   input  logic [1:0]        irq_mode,
   input  logic              rd_en,
   output logic [HOST_W-1:0] rd_data,
   output logic              rx_ready,
   output logic              rx_event,
   output logic              rx_irq,
   output logic              rx_overrun
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("framed_rx: WORD_W must be at least 2");
      end
      if (HOST_W < WORD_W) begin : g_bad_host
         $error("framed_rx: HOST_W must not be below WORD_W");
      end
      if (FRAME_WORDS < 1) begin : g_bad_frame
         $error("framed_rx: FRAME_WORDS must be at least 1");
      end
      if (DELAY < 0 || DELAY > 2) begin : g_bad_delay
         $error("framed_rx: DELAY must be 0, 1 or 2");
      end
      if (JUSTIFY != JUST_RIGHT && JUSTIFY != JUST_LEFT) begin : g_bad_just
         $error("framed_rx: JUSTIFY must be 0 or 1");
      end
   endgenerate

   logic              w_valid;
   logic [WORD_W-1:0] w_data;
   logic              w_last;
   logic              sync_pulse;
   logic [WORD_W-1:0] dreg;
   logic              load_last;
   logic              ovr_pulse;

   frx_deser #(
      .WORD_W      (WORD_W),
      .FRAME_WORDS (FRAME_WORDS),
      .DELAY       (DELAY)
   ) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (rx_enable),
      .bit_tick   (bit_tick),
      .fsync      (rx_fsync),
      .sdata      (rx_sdata),
      .word_valid (w_valid),
      .word_data  (w_data),
      .word_last  (w_last),
      .sync_seen  (sync_pulse)
   );

   frx_buffer #(
      .WORD_W (WORD_W)
   ) u_buffer (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (rx_enable),
      .in_valid   (w_valid),
      .in_data    (w_data),
      .in_last    (w_last),
      .rd_en      (rd_en),
      .out_data   (dreg),
      .ready      (rx_ready),
      .overrun    (rx_overrun),
      .load_pulse (rx_event),
      .load_last  (load_last),
      .ovr_pulse  (ovr_pulse)
   );

   frx_justify #(
      .WORD_W  (WORD_W),
      .HOST_W  (HOST_W),
      .JUSTIFY (JUSTIFY)
   ) u_justify (
      .word (dreg),
      .host (rd_data)
   );

   frx_irq u_irq (
      .mode       (irq_mode),
      .load_pulse (rx_event),
      .load_last  (load_last),
      .sync_pulse (sync_pulse),
      .ovr_pulse  (ovr_pulse),
      .irq        (rx_irq)
   );

endmodule

// File: rtl/frx_checker.sv
module frx_checker #(
   parameter int HOST_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_enable,
   input logic              rd_en,
   input logic [1:0]        irq_mode,
   input logic [HOST_W-1:0] rd_data,
   input logic              rx_ready,
   input logic              rx_event,
   input logic              rx_irq,
   input logic              rx_overrun
);

   // R1: a disabled receiver shows no word and no overrun
   p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> (!rx_ready && !rx_overrun));

   // R6: an unread word is held with its data
   p_hold_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !rd_en && rx_enable) |=> (rx_ready && $stable(rd_data)));

   // R6: a read drops the ready flag
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rx_ready && rx_enable) |=> !rx_ready);

   // R8: overrun is sticky while enabled
   p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun && rx_enable) |=> rx_overrun);

   // R9: each event marks a freshly loaded word
   p_event_on_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |-> $rose(rx_ready));

   // R10: element mode follows the event
   p_irq_elem_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode == 2'b00) |-> (rx_irq == rx_event));

   // R11: frame-end interrupt only with a delivered word
   p_irq_frame_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_mode == 2'b01) && rx_irq) |-> rx_event);

   // R13: overrun interrupt only with the flag set
   p_irq_overrun_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_mode == 2'b11) && rx_irq) |-> rx_overrun);

endmodule

bind framed_rx frx_checker #(.HOST_W(HOST_W)) u_frx_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_enable  (rx_enable),
   .rd_en      (rd_en),
   .irq_mode   (irq_mode),
   .rd_data    (rd_data),
   .rx_ready   (rx_ready),
   .rx_event   (rx_event),
   .rx_irq     (rx_irq),
   .rx_overrun (rx_overrun)
);

// File: tb/tb_framed_rx.sv
`timescale 1ns/1ps
module tb_framed_rx;

   localparam int TICK_GAP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_enable = 1'b0;
   logic        bit_tick = 1'b0;
   logic        rx_fsync = 1'b0;
   logic        rx_sdata = 1'b0;
   logic [1:0]  irq_mode = 2'b00;
   logic        auto_rd = 1'b0;
   logic        man_rd = 1'b0;
   logic        rd_en;
   logic [31:0] rd_data, rd_data_l;
   logic        rx_ready, rx_event, rx_irq, rx_overrun;
   logic        rdy_l, ev_l, irq_l, ovr_l;

   int tests = 0;
   int fails = 0;
   int ev_cnt = 0;
   int irq_cnt = 0;
   bit auto_read = 1'b1;
   bit done = 1'b0;
   logic [7:0] exp_q[$];

   assign rd_en = auto_rd | man_rd;

   always #2.5 clk = ~clk;

   framed_rx dut (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_tick(bit_tick),
      .rx_fsync(rx_fsync), .rx_sdata(rx_sdata), .irq_mode(irq_mode), .rd_en(rd_en),
      .rd_data(rd_data), .rx_ready(rx_ready), .rx_event(rx_event), .rx_irq(rx_irq),
      .rx_overrun(rx_overrun)
   );

   framed_rx #(.JUSTIFY(1)) dut_l (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_tick(bit_tick),
      .rx_fsync(rx_fsync), .rx_sdata(rx_sdata), .irq_mode(irq_mode), .rd_en(rd_en),
      .rd_data(rd_data_l), .rx_ready(rdy_l), .rx_event(ev_l), .rx_irq(irq_l),
      .rx_overrun(ovr_l)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rx_irq) irq_cnt++;
      if (rx_event) begin
         ev_cnt++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected word", rd_data, 32'h0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rd_data === {24'h0, e}, "R3/R5/R9 right-justified word", rd_data, {24'h0, e});
            chk(rd_data_l === {e, 24'h0}, "R5 left-justified word", rd_data_l, {e, 24'h0});
         end
         auto_rd = auto_read;
      end else begin
         auto_rd = 1'b0;
      end
   end

   task automatic tick_bit(input logic fs, input logic d);
      @(negedge clk);
      bit_tick = 1'b1; rx_fsync = fs; rx_sdata = d;
      @(negedge clk);
      bit_tick = 1'b0; rx_fsync = 1'b0;
      repeat (TICK_GAP - 1) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] w0, input logic [7:0] w1,
                             input bit push, input bit glitch, input bit chk_lat);
      logic [15:0] bits;
      bits = {w0, w1};
      if (push) begin
         exp_q.push_back(w0);
         exp_q.push_back(w1);
      end
      // sync tick carries a bit that must be discarded (R3)
      @(negedge clk);
      bit_tick = 1'b1; rx_fsync = 1'b1; rx_sdata = ~w0[7];
      @(negedge clk);
      bit_tick = 1'b0; rx_fsync = 1'b0;
      if (irq_mode == 2'b10 && rx_enable)
         chk(rx_irq === 1'b1, "R12 sync interrupt timing", {31'h0, rx_irq}, 32'h1);
      repeat (TICK_GAP - 1) @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         if (i == 15 && chk_lat) begin
            @(negedge clk);
            bit_tick = 1'b1; rx_sdata = bits[15-i];
            @(negedge clk);
            bit_tick = 1'b0;
            @(negedge clk);
            chk(rx_ready === 1'b0, "R4 ready not yet after one edge", {31'h0, rx_ready}, 32'h0);
            @(negedge clk);
            chk(rx_ready === 1'b1 && rx_event === 1'b1, "R4 ready and event after two edges",
                {30'h0, rx_ready, rx_event}, 32'h3);
            repeat (TICK_GAP - 2) @(negedge clk);
         end else begin
            tick_bit(glitch && (i == 3), bits[15-i]);
         end
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic host_read();
      @(negedge clk);
      man_rd = 1'b1;
      @(negedge clk);
      man_rd = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int e0, i0;
      repeat (4) @(negedge clk);
      chk(rx_ready === 1'b0 && rx_overrun === 1'b0 && rx_event === 1'b0 && rx_irq === 1'b0,
          "R1 reset state", {28'h0, rx_ready, rx_overrun, rx_event, rx_irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rx_enable = 1'b1;
      repeat (2) @(negedge clk);

      // R2: data without a frame sync yields nothing
      e0 = ev_cnt;
      for (int i = 0; i < 20; i++) tick_bit(1'b0, i[0] ^ i[2]);
      repeat (4) @(negedge clk);
      chk(ev_cnt == e0 && rx_ready === 1'b0, "R2 no word without sync", ev_cnt - e0, 0);

      // R10: element interrupt, latency, glitch sync
      irq_mode = 2'b00;
      e0 = ev_cnt; i0 = irq_cnt;
      send_frame(8'hA5, 8'h3C, 1'b1, 1'b0, 1'b1);
      send_frame(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0);
      send_frame(8'h81, 8'h7E, 1'b1, 1'b0, 1'b0);
      chk(ev_cnt - e0 == 6, "R2/R9 six words from three frames", ev_cnt - e0, 6);
      chk(irq_cnt - i0 == 6, "R10 one interrupt per word", irq_cnt - i0, 6);

      // R11: frame-end interrupt
      irq_mode = 2'b01;
      e0 = ev_cnt; i0 = irq_cnt;
      send_frame(8'h5A, 8'hC3, 1'b1, 1'b0, 1'b0);
      send_frame(8'h01, 8'h80, 1'b1, 1'b0, 1'b0);
      chk(ev_cnt - e0 == 4, "R9 four words", ev_cnt - e0, 4);
      chk(irq_cnt - i0 == 2, "R11 one interrupt per frame", irq_cnt - i0, 2);

      // R12: sync interrupt
      irq_mode = 2'b10;
      i0 = irq_cnt;
      send_frame(8'h69, 8'h96, 1'b1, 1'b0, 1'b0);
      send_frame(8'hF0, 8'h0F, 1'b1, 1'b0, 1'b0);
      chk(irq_cnt - i0 == 2, "R12 one interrupt per sync", irq_cnt - i0, 2);

      // R1: a frame sent before enabling is lost
      irq_mode = 2'b00;
      rx_enable = 1'b0;
      e0 = ev_cnt;
      send_frame(8'hDE, 8'hAD, 1'b0, 1'b0, 1'b0);
      chk(ev_cnt == e0 && rx_ready === 1'b0, "R1 frame lost while disabled", ev_cnt - e0, 0);
      rx_enable = 1'b1;
      send_frame(8'h12, 8'h34, 1'b1, 1'b0, 1'b0);
      chk(ev_cnt - e0 == 2, "R1 frame received once enabled", ev_cnt - e0, 2);

      // R8/R13/R6/R7: overrun with reads held off
      irq_mode = 2'b11;
      auto_read = 1'b0;
      e0 = ev_cnt; i0 = irq_cnt;
      send_frame(8'hC3, 8'h5A, 1'b1, 1'b0, 1'b0);
      chk(rx_overrun === 1'b0, "R8 no overrun with buffer room", {31'h0, rx_overrun}, 32'h0);
      send_frame(8'h11, 8'h22, 1'b0, 1'b0, 1'b0);
      chk(rx_overrun === 1'b1, "R8 overrun set", {31'h0, rx_overrun}, 32'h1);
      chk(irq_cnt - i0 == 2, "R13 interrupt per dropped word", irq_cnt - i0, 2);
      chk(ev_cnt - e0 == 1, "R8 only first word delivered", ev_cnt - e0, 1);
      chk(rx_ready === 1'b1 && rd_data === 32'h0000_00C3, "R6/R8 held word kept",
          rd_data, 32'h0000_00C3);
      host_read();
      chk(rx_ready === 1'b0, "R6 read clears ready", {31'h0, rx_ready}, 32'h0);
      @(negedge clk);
      chk(rx_ready === 1'b1 && rx_event === 1'b1 && rd_data === 32'h0000_005A,
          "R7 buffered word follows next cycle", rd_data, 32'h0000_005A);
      host_read();
      @(negedge clk);
      chk(rx_ready === 1'b0, "R7 nothing further pending", {31'h0, rx_ready}, 32'h0);
      chk(rx_overrun === 1'b1, "R8 overrun sticky", {31'h0, rx_overrun}, 32'h1);
      rx_enable = 1'b0;
      @(negedge clk);
      chk(rx_overrun === 1'b0 && rx_ready === 1'b0, "R1 disable clears flags",
          {30'h0, rx_overrun, rx_ready}, 32'h0);
      chk(exp_q.size() == 0, "R9 every expected word delivered", exp_q.size(), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule